// File: doc/BRIEF.md
# Ternary Phase Vote Combiner

This block collapses several per-lane early/late decisions, all taken from one deserialized word, into one ternary vote for the clock-recovery loop filter. Each lane supplies a signed two-bit code meaning advance (+1), retard (-1) or no information (0). The block forms the signed sum of the lanes and passes on only its sign. Lanes that report 0 therefore abstain, and a tie between opposing lanes produces no update instead of a forced direction.

The vote is registered. It appears one clock after a strobed input word, and a valid flag travels alongside it. While the strobe is low the previous vote is held. The lane count is a parameter. The default is four lanes.

Top module: `vote_combiner`

## Requirements
- R1: While reset is active (rst_n low), and after it is released until the first valid word, `vote` is 2'b00 and `vote_valid` is 0.
- R2: A lane code 2'b01 means +1, 2'b11 means -1 and 2'b00 means 0. Lane k occupies bits [2k+1:2k] of `in_lanes`. `vote` uses the same encoding and never takes the value 2'b10.
- R3: A lane code of 2'b10 is illegal and counts as 0.
- R4: When more lanes report +1 than -1, the vote is 2'b01.
- R5: When more lanes report -1 than +1, the vote is 2'b11.
- R6: When the +1 and -1 counts are equal, the vote is 2'b00. This covers an all-zero word and balanced opposing lanes.
- R7: The vote does not depend on which lane carries which code.
- R8: A valid word's vote is present at `vote` after the next rising clock edge. `vote_valid` equals the `in_valid` sampled at that edge.
- R9: While `in_valid` is low, `vote` keeps its previous value whatever `in_lanes` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe marking a valid lane word |
| in_lanes | input | 2*NUM_LANES | Packed ternary lane codes, lane 0 in the low bits |
| vote_valid | output | 1 | Registered copy of the strobe |
| vote | output | 2 | Registered ternary vote |

## Verification
Every result is due exactly one rising edge after the word is driven. The bench drives inputs on the falling edge, waits for the next rising edge, and samples one nanosecond later. The same timing applies to strobed words, to hold cycles with the strobe low, and to the valid flag. The bench keeps a running model of the held vote, so each sample is compared with the value that edge should have produced and never with a later one.

// File: rtl/vote_pkg.sv
package vote_pkg;
  localparam int CODE_W = 2;
  typedef logic [CODE_W-1:0] tern_t;

  localparam tern_t TERN_ZERO = 2'b00;
  localparam tern_t TERN_POS  = 2'b01;
  localparam tern_t TERN_NEG  = 2'b11;

  // Only the two exact codes carry a direction; 2'b10 falls through as zero.
  function automatic logic is_pos(tern_t c);
    return c == TERN_POS;
  endfunction

  function automatic logic is_neg(tern_t c);
    return c == TERN_NEG;
  endfunction

  // Sign of (plus - minus), expressed through the two counts.
  function automatic tern_t resolve(int unsigned n_plus, int unsigned n_minus);
    if (n_plus > n_minus)      return TERN_POS;
    else if (n_minus > n_plus) return TERN_NEG;
    else                       return TERN_ZERO;
  endfunction
endpackage

// File: rtl/vote_lane_decode.sv
module vote_lane_decode
  import vote_pkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input  logic [NUM_LANES*CODE_W-1:0] lanes,
  output logic [NUM_LANES-1:0]        pos_mask,
  output logic [NUM_LANES-1:0]        neg_mask
);
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign pos_mask[g] = is_pos(lanes[g*CODE_W +: CODE_W]);
    assign neg_mask[g] = is_neg(lanes[g*CODE_W +: CODE_W]);
  end
endmodule

// File: rtl/vote_tally.sv
module vote_tally
  import vote_pkg::*;
#(
  parameter int NUM_LANES = 4,
  localparam int CNT_W = $clog2(NUM_LANES + 1)
) (
  input  logic [NUM_LANES-1:0] pos_mask,
  input  logic [NUM_LANES-1:0] neg_mask,
  output logic [CNT_W-1:0]     n_plus,
  output logic [CNT_W-1:0]     n_minus,
  output tern_t                sign_out
);
  always_comb begin
    n_plus  = '0;
    n_minus = '0;
    for (int k = 0; k < NUM_LANES; k++) begin
      n_plus  = n_plus  + CNT_W'(pos_mask[k]);
      n_minus = n_minus + CNT_W'(neg_mask[k]);
    end
  end

  assign sign_out = resolve(32'(n_plus), 32'(n_minus));
endmodule

// File: rtl/vote_combiner.sv
module vote_combiner
  import vote_pkg::*;
#(
  parameter int NUM_LANES = 4,
  localparam int CNT_W = $clog2(NUM_LANES + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [NUM_LANES*CODE_W-1:0] in_lanes,
  output logic                        vote_valid,
  output logic [CODE_W-1:0]           vote
);
  logic [NUM_LANES-1:0] pos_mask;
  logic [NUM_LANES-1:0] neg_mask;
  logic [CNT_W-1:0]     n_plus;
  logic [CNT_W-1:0]     n_minus;
  tern_t                next_vote;

  vote_lane_decode #(.NUM_LANES(NUM_LANES)) u_decode (
    .lanes    (in_lanes),
    .pos_mask (pos_mask),
    .neg_mask (neg_mask)
  );

  vote_tally #(.NUM_LANES(NUM_LANES)) u_tally (
    .pos_mask (pos_mask),
    .neg_mask (neg_mask),
    .n_plus   (n_plus),
    .n_minus  (n_minus),
    .sign_out (next_vote)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vote       <= TERN_ZERO;
      vote_valid <= 1'b0;
    end else begin
      vote_valid <= in_valid;
      if (in_valid) vote <= next_vote;
    end
  end

  // R8: the flag tracks the strobe one edge later
  a_r8_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> vote_valid);
  a_r8_valid_low: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !vote_valid);
  // R9: no strobe, no change
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(vote));
  // R4, R5, R6: registered vote agrees with the lane counts
  a_r4_majority_pos: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && n_plus > n_minus) |=> vote == TERN_POS);
  a_r5_majority_neg: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && n_minus > n_plus) |=> vote == TERN_NEG);
  a_r6_tie_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && n_minus == n_plus) |=> vote == TERN_ZERO);
  // R2: output never carries the illegal code
  a_r2_legal_out: assert property (@(posedge clk) disable iff (!rst_n)
    vote != 2'b10);
  // R3: a lane is counted at most once, as plus or as minus
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(n_plus) + 32'(n_minus) <= NUM_LANES);
endmodule

// File: tb/vote_combiner_test.sv
module vote_combiner_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_lanes;
  logic       vote_valid;
  logic [1:0] vote;

  int checks = 0;
  int errors = 0;
  logic [1:0] model_vote = 2'b00;

  always #2.5 clk = ~clk;

  vote_combiner #(.NUM_LANES(4)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_lanes(in_lanes),
    .vote_valid(vote_valid), .vote(vote)
  );

  function automatic logic [1:0] expect_vote(logic [7:0] w);
    int s = 0;
    for (int k = 0; k < 4; k++) begin
      if (w[2*k +: 2] == 2'b01) s = s + 1;
      if (w[2*k +: 2] == 2'b11) s = s - 1;
    end
    if (s > 0) return 2'b01;
    if (s < 0) return 2'b11;
    return 2'b00;
  endfunction

  function automatic logic has_illegal(logic [7:0] w);
    for (int k = 0; k < 4; k++) if (w[2*k +: 2] == 2'b10) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(string req, logic [1:0] got, logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  // drive on falling edge, sample 1 ns after the capturing rising edge
  task automatic step(logic [7:0] w, logic v);
    @(negedge clk);
    in_lanes = w;
    in_valid = v;
    @(posedge clk);
    #1;
    if (v) model_vote = expect_vote(w);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [1:0] rot_a;
    rst_n = 1'b0; in_valid = 1'b0; in_lanes = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 vote in reset", vote, 2'b00);
    chk("R1 valid in reset", {1'b0, vote_valid}, 2'b00);
    @(negedge clk); rst_n = 1'b1;
    step(8'b01_01_11_11, 1'b0);
    chk("R1 vote after reset", vote, 2'b00);
    chk("R1 valid after reset", {1'b0, vote_valid}, 2'b00);

    // exhaustive sweep of all lane words, including illegal codes
    for (int i = 0; i < 256; i++) begin
      step(8'(i), 1'b1);
      if (has_illegal(8'(i)))             chk("R3 illegal lane as zero", vote, model_vote);
      else if (model_vote == 2'b01)       chk("R4 positive sum", vote, model_vote);
      else if (model_vote == 2'b11)       chk("R5 negative sum", vote, model_vote);
      else                                chk("R6 zero sum", vote, model_vote);
      chk("R8 valid follows strobe", {1'b0, vote_valid}, 2'b01);
      if ((i % 17) == 3) begin
        step(8'(255 - i), 1'b0);
        chk("R9 hold while idle", vote, model_vote);
        chk("R8 valid drops", {1'b0, vote_valid}, 2'b00);
      end
    end

    // explicit encodings and boundaries
    step(8'b00_00_00_01, 1'b1); chk("R2 single plus", vote, 2'b01);
    step(8'b11_00_00_00, 1'b1); chk("R2 single minus", vote, 2'b11);
    step(8'b10_10_10_01, 1'b1); chk("R3 illegal with one plus", vote, 2'b01);
    step(8'b10_10_10_10, 1'b1); chk("R3 all illegal", vote, 2'b00);
    step(8'b11_11_01_01, 1'b1); chk("R6 balanced pairs", vote, 2'b00);
    step(8'b11_01_01_01, 1'b1); chk("R4 three against one", vote, 2'b01);
    step(8'b01_11_11_11, 1'b1); chk("R5 three against one", vote, 2'b11);

    // R7: rotations of the same multiset agree
    step(8'b00_11_01_01, 1'b1); rot_a = vote;
    step(8'b01_01_00_11, 1'b1); chk("R7 lane order", vote, rot_a);
    step(8'b01_00_11_01, 1'b1); chk("R7 lane order", vote, rot_a);

    // R9: long idle run with changing lanes
    step(8'b11_11_11_11, 1'b1);
    for (int j = 0; j < 8; j++) begin
      step(8'(j * 37), 1'b0);
      chk("R9 hold vote", vote, 2'b11);
    end

    // R8: a valid word after idle lands one edge later
    step(8'b00_00_01_00, 1'b1);
    chk("R8 one cycle latency", vote, 2'b01);
    chk("R8 valid after idle", {1'b0, vote_valid}, 2'b01);

    finish_run();
  end
endmodule